// File: doc/BRIEF.md
# Byte-Wide Bus Interface Unit with Instruction Prefetch

This unit sits between a 16-bit processor core and an external bus whose data path is only 8 bits wide. It forms 20-bit physical addresses from a 16-bit segment and a 16-bit offset. It drives them over a bus in which the low 8 lines carry the address first and data afterwards, and the upper 12 lines carry only address. During the address phase it raises a latch strobe so that external logic can capture the address. A 16-bit operand transfer from the core is split into two byte cycles. Each cycle can be stretched by a ready input.

When no operand transfer is waiting, the unit fetches instruction bytes ahead of the core into a four-byte queue. The core takes bytes from the head of the queue. A branch request empties the queue, discards a fetch that is still on the bus, and restarts fetching at the branch target.

A single sequencer runs every bus cycle through the states ST_IDLE, ST_T1, ST_T2, ST_T3 and ST_T4. Each cycle is tagged CY_FETCH, CY_OPLO or CY_OPHI. The transitions are:
- start: ST_IDLE or ST_T4 to ST_T1, when an operand or fetch cycle is picked.
- address-done: ST_T1 to ST_T2.
- strobe: ST_T2 to ST_T3.
- wait: ST_T3 to ST_T3, while ready is low.
- release: ST_T3 to ST_T4, when ready is high.
- high-byte: ST_T4 to ST_T1, for the second byte of a word.
- park: ST_T4 to ST_IDLE, when nothing is pending.

Top module: `biu8_core`

## Requirements
- R1: While rst_n is low, ale=0, rd_n=1, wr_n=1, ad_oe=0, op_done=0, q_valid=0 and q_count=0. After reset the fetch origin is segment 0, offset 0.
- R2: A memory cycle puts the address ((segment<<4)+offset) mod 2^20 on {addr_hi, ad_out} while ale is high. An I/O cycle puts the 16-bit port number there, zero-extended. ale is high for exactly one clock per bus cycle, in ST_T1.
- R3: Every cycle runs ST_T1, ST_T2, ST_T3 (repeated while waiting) and ST_T4. rd_n or wr_n is low in ST_T2 and ST_T3, and never both at once. ad_oe is 0 while rd_n is low. During a write, ad_out carries the data byte while wr_n is low. io_m=1 marks an I/O cycle and io_m=0 a memory cycle.
- R4: ready is sampled only in ST_T3. Each low sample repeats ST_T3 and keeps the strobe low. A cycle finishes one clock after ready is seen high.
- R5: Read data on ad_in is captured on the clock edge that leaves ST_T3.
- R6: A word transfer (op_word=1) moves the low byte at address A first and the high byte at A+1 second. For memory, A+1 wraps modulo 2^20. For I/O, the port number wraps modulo 2^16. op_rdata={high,low}. A byte transfer runs one cycle and returns op_rdata[15:8]=0.
- R7: op_done is high for one clock, in ST_T4 of the last byte cycle of the transfer. The operand fields are sampled when the first cycle starts.
- R8: The queue holds at most 4 bytes, and q_count never exceeds 4. q_byte shows the oldest byte. q_pop while q_valid=1 removes that byte. Bytes leave the queue in fetch order.
- R9: A fetch cycle starts only when q_count<4, op_req=0 and br_req=0. The fetch offset advances by one per byte queued and wraps within 16 bits.
- R10: A waiting operand request is delayed by at most the one fetch cycle already on the bus, so a word transfer completes within three bus cycles of the request.
- R11: A br_req pulse leaves q_count=0 on the following clock and ignores q_pop in that clock. A fetch byte still on the bus is dropped. The next byte delivered comes from (br_seg<<4)+br_off.
- R12: With the queue full and no operand request, the bus stays idle and ale stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_req | input | 1 | Operand transfer request, held until op_done |
| op_write | input | 1 | 1 = write, 0 = read |
| op_io | input | 1 | 1 = I/O space, 0 = memory |
| op_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| op_seg | input | 16 | Operand segment value |
| op_off | input | 16 | Operand offset or port number |
| op_wdata | input | 16 | Write data |
| op_done | output | 1 | Transfer complete pulse |
| op_rdata | output | 16 | Read data, valid with op_done |
| br_req | input | 1 | Branch: flush queue and reload fetch pointer |
| br_seg | input | 16 | Branch target segment |
| br_off | input | 16 | Branch target offset |
| q_pop | input | 1 | Remove head byte of the queue |
| q_valid | output | 1 | Queue holds at least one byte |
| q_byte | output | 8 | Head byte of the queue |
| q_count | output | 3 | Bytes in the queue |
| ale | output | 1 | Address latch strobe |
| addr_hi | output | 12 | Address bits 19..8 |
| ad_out | output | 8 | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for the multiplexed lines |
| ad_in | input | 8 | Multiplexed lines in (read data) |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| ready | input | 1 | 0 inserts a wait state in ST_T3 |

## Verification
The clocked checks rely on three conditions that the core and the system must meet. The core keeps op_req high until it sees op_done and drops it at once. The core never raises br_req while an operand transfer is outstanding. ready always has a defined level. The stimulus meets all three by running each transfer to completion in sequence, issuing branches only between transfers, and driving ready from either a fixed level or a random draw on every falling edge.

// File: rtl/biu8_pkg.sv
package biu8_pkg;
    localparam int ADDR_W  = 20;
    localparam int SEG_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int Q_DEPTH = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_T4
    } bus_state_e;

    typedef enum logic [1:0] {
        CY_FETCH,
        CY_OPLO,
        CY_OPHI
    } cyc_kind_e;
endpackage

// File: rtl/biu8_agen.sv
module biu8_agen #(
    parameter int AW = 20,
    parameter int SW = 16
) (
    input  logic [SW-1:0] seg,
    input  logic [SW-1:0] off,
    input  logic          io,
    input  logic          hi,
    output logic [AW-1:0] addr
);
    localparam int PAD = AW - SW;

    logic [AW-1:0] mem_base;
    logic [AW-1:0] io_lo;
    logic [AW-1:0] io_hi;

    always_comb begin
        mem_base = ({{PAD{1'b0}}, seg} << PAD) + {{PAD{1'b0}}, off};
        io_lo    = {{PAD{1'b0}}, off};
        io_hi    = {{PAD{1'b0}}, off + SW'(1)};
        if (io) begin
            addr = hi ? io_hi : io_lo;
        end else begin
            addr = hi ? (mem_base + AW'(1)) : mem_base;
        end
    end
endmodule

// File: rtl/biu8_queue.sv
module biu8_queue #(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          valid,
    output logic [CW-1:0] count
);
    logic [DW-1:0] slot [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    assign do_push = push && !flush && (cnt < CW'(DEPTH));
    assign do_pop  = pop && !flush && (cnt != '0);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && (wr_ptr == PW'(g))) begin
                slot[g] <= din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
            end
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    assign dout  = slot[rd_ptr];
    assign valid = (cnt != '0);
    assign count = cnt;
endmodule

// File: rtl/biu8_fetch.sv
module biu8_fetch #(
    parameter int AW = 20,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          br_req,
    input  logic [SW-1:0] br_seg,
    input  logic [SW-1:0] br_off,
    input  logic          advance,
    output logic [AW-1:0] pf_addr
);
    logic [SW-1:0] code_seg;
    logic [SW-1:0] fetch_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_seg  <= '0;
            fetch_off <= '0;
        end else if (br_req) begin
            code_seg  <= br_seg;
            fetch_off <= br_off;
        end else if (advance) begin
            fetch_off <= fetch_off + SW'(1);
        end
    end

    biu8_agen #(.AW(AW), .SW(SW)) u_pf_agen (
        .seg  (code_seg),
        .off  (fetch_off),
        .io   (1'b0),
        .hi   (1'b0),
        .addr (pf_addr)
    );
endmodule

// File: rtl/biu8_seq.sv
module biu8_seq import biu8_pkg::*; #(
    parameter int AW = ADDR_W,
    parameter int SW = SEG_W,
    parameter int DW = BYTE_W,
    localparam int WW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_req,
    input  logic          op_write,
    input  logic          op_io,
    input  logic          op_word,
    input  logic [SW-1:0] op_seg,
    input  logic [SW-1:0] op_off,
    input  logic [WW-1:0] op_wdata,
    output logic          op_done,
    output logic [WW-1:0] op_rdata,
    input  logic          br_req,
    input  logic          q_space,
    input  logic [AW-1:0] pf_addr,
    output logic          fetch_push,
    output logic [DW-1:0] fetch_byte,
    output logic          ale,
    output logic [AW-DW-1:0] addr_hi,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    input  logic [DW-1:0] ad_in,
    output logic          rd_n,
    output logic          wr_n,
    output logic          io_m,
    input  logic          ready
);
    bus_state_e state_q, state_d;
    cyc_kind_e  kind_q, kind_d;

    logic [AW-1:0] cyc_addr_q;
    logic          cyc_wr_q;
    logic          cyc_io_q;
    logic [DW-1:0] cyc_wdat_q;
    logic          stale_q;

    logic          opl_wr, opl_io, opl_word;
    logic [SW-1:0] opl_seg, opl_off;
    logic [WW-1:0] opl_wdata;
    logic [DW-1:0] rdata_lo_q, rdata_hi_q;

    logic          bus_free, need_hi, op_final, start_op, start_pf;
    logic          in_strobe;
    logic [SW-1:0] ag_seg, ag_off;
    logic          ag_io;
    logic [AW-1:0] ag_addr;

    assign bus_free = (state_q == ST_IDLE) || (state_q == ST_T4);
    assign need_hi  = (state_q == ST_T4) && (kind_q == CY_OPLO) && opl_word;
    assign op_final = (state_q == ST_T4) && (kind_q != CY_FETCH) && !need_hi;
    assign start_op = bus_free && !need_hi && !op_final && op_req;
    assign start_pf = bus_free && !need_hi && !op_req && !br_req && q_space;

    assign ag_seg = need_hi ? opl_seg : op_seg;
    assign ag_off = need_hi ? opl_off : op_off;
    assign ag_io  = need_hi ? opl_io  : op_io;

    biu8_agen #(.AW(AW), .SW(SW)) u_op_agen (
        .seg  (ag_seg),
        .off  (ag_off),
        .io   (ag_io),
        .hi   (need_hi),
        .addr (ag_addr)
    );

    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_op) begin
                    state_d = ST_T1;
                    kind_d  = CY_OPLO;
                end else if (start_pf) begin
                    state_d = ST_T1;
                    kind_d  = CY_FETCH;
                end
            end
            ST_T1: state_d = ST_T2;
            ST_T2: state_d = ST_T3;
            ST_T3: begin
                if (ready) begin
                    state_d = ST_T4;
                end
            end
            ST_T4: begin
                if (need_hi) begin
                    state_d = ST_T1;
                    kind_d  = CY_OPHI;
                end else if (start_op) begin
                    state_d = ST_T1;
                    kind_d  = CY_OPLO;
                end else if (start_pf) begin
                    state_d = ST_T1;
                    kind_d  = CY_FETCH;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= CY_FETCH;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_addr_q <= '0;
            cyc_wr_q   <= 1'b0;
            cyc_io_q   <= 1'b0;
            cyc_wdat_q <= '0;
            stale_q    <= 1'b0;
            opl_wr     <= 1'b0;
            opl_io     <= 1'b0;
            opl_word   <= 1'b0;
            opl_seg    <= '0;
            opl_off    <= '0;
            opl_wdata  <= '0;
            rdata_lo_q <= '0;
            rdata_hi_q <= '0;
        end else begin
            if (state_d == ST_T1) begin
                stale_q <= 1'b0;
                unique case (kind_d)
                    CY_OPLO: begin
                        cyc_addr_q <= ag_addr;
                        cyc_wr_q   <= op_write;
                        cyc_io_q   <= op_io;
                        cyc_wdat_q <= op_wdata[DW-1:0];
                        opl_wr     <= op_write;
                        opl_io     <= op_io;
                        opl_word   <= op_word;
                        opl_seg    <= op_seg;
                        opl_off    <= op_off;
                        opl_wdata  <= op_wdata;
                        rdata_hi_q <= '0;
                    end
                    CY_OPHI: begin
                        cyc_addr_q <= ag_addr;
                        cyc_wr_q   <= opl_wr;
                        cyc_io_q   <= opl_io;
                        cyc_wdat_q <= opl_wdata[WW-1:DW];
                    end
                    CY_FETCH: begin
                        cyc_addr_q <= pf_addr;
                        cyc_wr_q   <= 1'b0;
                        cyc_io_q   <= 1'b0;
                    end
                    default: ;
                endcase
            end else if (br_req && (kind_q == CY_FETCH) &&
                         (state_q == ST_T1 || state_q == ST_T2 || state_q == ST_T3)) begin
                stale_q <= 1'b1;
            end

            if ((state_q == ST_T3) && ready && !cyc_wr_q) begin
                if (kind_q == CY_OPLO) begin
                    rdata_lo_q <= ad_in;
                end
                if (kind_q == CY_OPHI) begin
                    rdata_hi_q <= ad_in;
                end
            end
        end
    end

    assign in_strobe = (state_q == ST_T2) || (state_q == ST_T3);

    always_comb begin
        ale        = (state_q == ST_T1);
        addr_hi    = cyc_addr_q[AW-1:DW];
        ad_out     = '0;
        ad_oe      = 1'b0;
        rd_n       = 1'b1;
        wr_n       = 1'b1;
        io_m       = (state_q != ST_IDLE) && cyc_io_q;
        op_done    = op_final;
        op_rdata   = {rdata_hi_q, rdata_lo_q};
        fetch_push = (state_q == ST_T3) && ready && (kind_q == CY_FETCH) &&
                     !stale_q && !br_req;
        fetch_byte = ad_in;
        if (state_q == ST_T1) begin
            ad_out = cyc_addr_q[DW-1:0];
            ad_oe  = 1'b1;
        end else if (state_q != ST_IDLE && cyc_wr_q) begin
            ad_out = cyc_wdat_q;
            ad_oe  = 1'b1;
        end
        if (in_strobe) begin
            rd_n = cyc_wr_q;
            wr_n = !cyc_wr_q;
        end
    end
endmodule

// File: rtl/biu8_core.sv
module biu8_core import biu8_pkg::*; #(
    parameter int AW     = ADDR_W,
    parameter int SW     = SEG_W,
    parameter int DW     = BYTE_W,
    parameter int QDEPTH = Q_DEPTH,
    localparam int WW    = 2 * DW,
    localparam int CW    = $clog2(QDEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_req,
    input  logic             op_write,
    input  logic             op_io,
    input  logic             op_word,
    input  logic [SW-1:0]    op_seg,
    input  logic [SW-1:0]    op_off,
    input  logic [WW-1:0]    op_wdata,
    output logic             op_done,
    output logic [WW-1:0]    op_rdata,
    input  logic             br_req,
    input  logic [SW-1:0]    br_seg,
    input  logic [SW-1:0]    br_off,
    input  logic             q_pop,
    output logic             q_valid,
    output logic [DW-1:0]    q_byte,
    output logic [CW-1:0]    q_count,
    output logic             ale,
    output logic [AW-DW-1:0] addr_hi,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_in,
    output logic             rd_n,
    output logic             wr_n,
    output logic             io_m,
    input  logic             ready
);
    logic          fetch_push;
    logic [DW-1:0] fetch_byte;
    logic [AW-1:0] pf_addr;
    logic          q_space;

    assign q_space = (q_count < CW'(QDEPTH));

    biu8_fetch #(.AW(AW), .SW(SW)) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .br_req  (br_req),
        .br_seg  (br_seg),
        .br_off  (br_off),
        .advance (fetch_push),
        .pf_addr (pf_addr)
    );

    biu8_queue #(.DW(DW), .DEPTH(QDEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (br_req),
        .push  (fetch_push),
        .din   (fetch_byte),
        .pop   (q_pop),
        .dout  (q_byte),
        .valid (q_valid),
        .count (q_count)
    );

    biu8_seq #(.AW(AW), .SW(SW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_req     (op_req),
        .op_write   (op_write),
        .op_io      (op_io),
        .op_word    (op_word),
        .op_seg     (op_seg),
        .op_off     (op_off),
        .op_wdata   (op_wdata),
        .op_done    (op_done),
        .op_rdata   (op_rdata),
        .br_req     (br_req),
        .q_space    (q_space),
        .pf_addr    (pf_addr),
        .fetch_push (fetch_push),
        .fetch_byte (fetch_byte),
        .ale        (ale),
        .addr_hi    (addr_hi),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .ad_in      (ad_in),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .io_m       (io_m),
        .ready      (ready)
    );
endmodule

// File: rtl/biu8_chk.sv
module biu8_chk #(
    parameter int QDEPTH = 4,
    parameter int CW     = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ale,
    input logic          rd_n,
    input logic          wr_n,
    input logic          ad_oe,
    input logic          ready,
    input logic          br_req,
    input logic          op_done,
    input logic [CW-1:0] q_count
);
    // R2
    ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R3
    read_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R3
    strobe_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(ale));

    // R4
    rd_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !ready) |=> !rd_n);

    // R4
    wr_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !ready) |=> !wr_n);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    // R8
    queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CW'(QDEPTH));

    // R11
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_req |=> (q_count == '0));
endmodule

bind biu8_core biu8_chk #(.QDEPTH(QDEPTH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .ad_oe   (ad_oe),
    .ready   (ready),
    .br_req  (br_req),
    .op_done (op_done),
    .q_count (q_count)
);

// File: tb/tb_biu8_core.sv
module tb_biu8_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_req = 1'b0, op_write = 1'b0, op_io = 1'b0, op_word = 1'b0;
    logic [15:0] op_seg = '0, op_off = '0, op_wdata = '0;
    logic        op_done;
    logic [15:0] op_rdata;
    logic        br_req = 1'b0;
    logic [15:0] br_seg = '0, br_off = '0;
    logic        q_pop = 1'b0;
    logic        q_valid;
    logic [7:0]  q_byte;
    logic [2:0]  q_count;
    logic        ale;
    logic [11:0] addr_hi;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in = '0;
    logic        rd_n, wr_n, io_m;
    logic        ready = 1'b1;

    always #2 clk = ~clk;

    biu8_core dut (.*);

    int n_chk = 0, n_bad = 0, cyc = 0, ale_cnt = 0;
    int ready_mode = 2;
    bit pop_on = 1'b0, br_pending = 1'b0, wr_taken = 1'b0;
    logic [15:0] nb_seg, nb_off, exp_seg = '0, exp_ip = '0;
    logic [19:0] lat_addr = '0;
    logic        lat_io = 1'b0;
    int          wr_cnt = 0;
    logic [19:0] wr_addr [2];
    logic [7:0]  wr_data [2];
    logic        wr_io   [2];

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        logic [19:0] r;
        r = {s, 4'h0} + {4'h0, o};
        return r;
    endfunction

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'hA};
    endfunction

    function automatic logic [7:0] io_byte(input logic [19:0] a);
        return ~(a[7:0] + a[15:8]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // one clock: external latch, memory, ready, queue consumer, branch driver
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            finish_run();
        end
        if (ale) begin
            lat_addr = {addr_hi, ad_out};
            lat_io   = io_m;
            wr_taken = 1'b0;
            ale_cnt++;
        end
        if (!rd_n) ad_in = lat_io ? io_byte(lat_addr) : mem_byte(lat_addr);
        if (!wr_n && !wr_taken) begin
            wr_taken = 1'b1;
            if (wr_cnt < 2) begin
                wr_addr[wr_cnt] = lat_addr;
                wr_data[wr_cnt] = ad_out;
                wr_io[wr_cnt]   = io_m;
            end
            wr_cnt++;
        end
        case (ready_mode)
            0: ready = 1'b0;
            1: ready = 1'b1;
            default: ready = ($urandom_range(0, 3) != 0);
        endcase
        if (br_pending) begin
            br_req = 1'b1; br_seg = nb_seg; br_off = nb_off;
            q_pop = 1'b0;
            exp_seg = nb_seg; exp_ip = nb_off;
            br_pending = 1'b0;
        end else begin
            br_req = 1'b0;
            if (pop_on && q_valid && ($urandom_range(0, 2) != 0)) begin
                chk("R8 R9 R11 fetch byte", {24'h0, q_byte}, {24'h0, mem_byte(phys(exp_seg, exp_ip))});
                exp_ip = exp_ip + 16'd1;
                q_pop = 1'b1;
            end else begin
                q_pop = 1'b0;
            end
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic branch(input logic [15:0] s, input logic [15:0] o);
        nb_seg = s; nb_off = o; br_pending = 1'b1;
        tick();
        tick();
        chk("R11 queue empty after flush", {29'h0, q_count}, 32'h0);
    endtask

    task automatic do_op(input logic wr, input logic io, input logic wd,
                         input logic [15:0] s, input logic [15:0] o, input logic [15:0] wdat);
        logic [19:0] a_lo, a_hi;
        logic [7:0]  b_lo, b_hi;
        int start_ale, nby, lim;
        a_lo = io ? {4'h0, o} : phys(s, o);
        a_hi = io ? {4'h0, o + 16'd1} : a_lo + 20'd1;
        b_lo = io ? io_byte(a_lo) : mem_byte(a_lo);
        b_hi = io ? io_byte(a_hi) : mem_byte(a_hi);
        nby  = wd ? 2 : 1;
        op_write = wr; op_io = io; op_word = wd; op_seg = s; op_off = o; op_wdata = wdat;
        op_req = 1'b1;
        wr_cnt = 0;
        start_ale = ale_cnt;
        lim = 0;
        do begin
            tick();
            lim++;
        end while (!op_done && lim < 300);
        op_req = 1'b0;
        chk("R7 op_done seen", {31'h0, op_done}, 32'h1);
        chk("R10 bus cycles until done", {31'h0, (ale_cnt - start_ale) <= nby + 1}, 32'h1);
        if (!wr) begin
            chk("R5 R6 read data", {16'h0, op_rdata}, {16'h0, (wd ? b_hi : 8'h00), b_lo});
        end else begin
            chk("R6 write cycle count", wr_cnt, nby);
            chk("R2 R6 low byte address", {12'h0, wr_addr[0]}, {12'h0, a_lo});
            chk("R3 low byte data", {24'h0, wr_data[0]}, {24'h0, wdat[7:0]});
            chk("R3 low byte space", {31'h0, wr_io[0]}, {31'h0, io});
            if (wd) begin
                chk("R2 R6 high byte address", {12'h0, wr_addr[1]}, {12'h0, a_hi});
                chk("R3 high byte data", {24'h0, wr_data[1]}, {24'h0, wdat[15:8]});
                chk("R3 high byte space", {31'h0, wr_io[1]}, {31'h0, io});
            end
        end
    endtask

    task automatic fill_queue();
        int lim = 0;
        pop_on = 1'b0;
        while (q_count != 3'd4 && lim < 400) begin
            tick();
            lim++;
        end
        ticks(3);
    endtask

    initial begin
        int snap;
        void'($urandom(32'd20240611));
        ticks(4);
        // R1 reset state
        chk("R1 ale", {31'h0, ale}, 32'h0);
        chk("R1 rd_n", {31'h0, rd_n}, 32'h1);
        chk("R1 wr_n", {31'h0, wr_n}, 32'h1);
        chk("R1 ad_oe", {31'h0, ad_oe}, 32'h0);
        chk("R1 op_done", {31'h0, op_done}, 32'h0);
        chk("R1 queue", {28'h0, q_valid, q_count}, 32'h0);
        rst_n = 1'b1;

        // R12 full queue parks the bus; R8 depth
        fill_queue();
        chk("R8 queue fills to four", {29'h0, q_count}, 32'h4);
        snap = ale_cnt;
        ticks(25);
        chk("R12 no bus cycle while full", ale_cnt - snap, 0);

        // R9 stream from reset origin
        pop_on = 1'b1;
        ticks(60);

        // R4 wait states and R5 capture
        fill_queue();
        ready_mode = 0;
        op_write = 1'b0; op_io = 1'b0; op_word = 1'b0;
        op_seg = 16'h1200; op_off = 16'h0345; op_req = 1'b1;
        ticks(15);
        chk("R4 stalled read not done", {31'h0, op_done}, 32'h0);
        chk("R4 strobe held in wait", {31'h0, rd_n}, 32'h0);
        ready_mode = 1;
        tick();
        chk("R4 not done on ready edge", {31'h0, op_done}, 32'h0);
        tick();
        chk("R4 done one clock after ready", {31'h0, op_done}, 32'h1);
        chk("R5 stalled read data", {16'h0, op_rdata}, {24'h0, mem_byte(phys(16'h1200, 16'h0345))});
        op_req = 1'b0;
        ticks(2);
        ready_mode = 2;

        // R11 flush, offset wrap in segment, stale fetch dropped
        pop_on = 1'b1;
        branch(16'hFFFF, 16'hFFFE);
        ticks(40);
        branch(16'h1234, 16'h0000);
        ticks(3);
        branch(16'h0040, 16'h0100);
        ticks(40);

        // R6 directed wrap cases
        do_op(1'b0, 1'b0, 1'b1, 16'hF000, 16'hFFFF, 16'h0);
        do_op(1'b1, 1'b1, 1'b1, 16'h0000, 16'hFFFF, 16'hBEEF);
        do_op(1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0010, 16'h5A3C);
        do_op(1'b0, 1'b1, 1'b1, 16'h0000, 16'h0380, 16'h0);
        do_op(1'b0, 1'b0, 1'b0, 16'h8000, 16'h7FFF, 16'h0);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r == 0) begin
                branch(16'($urandom), 16'($urandom));
            end else if (r <= 4) begin
                do_op(1'($urandom), 1'($urandom), 1'($urandom),
                      16'($urandom), 16'($urandom), 16'($urandom));
            end else begin
                ticks($urandom_range(1, 8));
            end
        end
        ticks(10);
        finish_run();
    end
endmodule